// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block handles a cache miss. It sits between a cache line buffer and a lower-level memory that sends a block back as a burst of words. When a miss arrives, the block captures the block address and the index of the word that missed. It then issues one burst request to memory and writes each returned word into its slot in the line buffer. When the word the processor is waiting for passes by, the block forwards it in the same cycle, so the processor can resume before the rest of the line has arrived.

Two fetch orders are selectable per miss:

- **Critical-word-first** (`critFirstMode` = 1): the burst starts at the missed word and wraps modulo the line length, so the missed word is the first beat.
- **Early restart** (`critFirstMode` = 0): the burst starts at word 0 and runs upward, and the missed word is forwarded when its turn in the sequence arrives.

With the default parameters a line is 64 bytes, which is sixteen 32-bit words. Memory may leave idle cycles between beats. A response is taken only in a cycle where its valid is high. Tag lookup and victim choice are handled elsewhere.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: After reset `missReady` is 1 and `memReqValid`, `fillWrEn`, `cpuRetValid` and `lineDone` are 0.
- R2: Each accepted miss produces exactly one memory request. It carries the captured block address and a start index equal to the missed word index when `critFirstMode` was 1, or 0 when it was 0. The request and its fields stay unchanged until `memReqReady` is seen high.
- R3: The k-th accepted beat (k counted from 0) is written to line position (start index + k) modulo 16, with `fillWrData` equal to the beat's data. Every one of the 16 positions is written exactly once per miss.
- R4: A beat is taken only in a cycle with `memRspValid` high. In wait cycles `fillWrEn` stays 0 and the beat count does not advance.
- R5: `cpuRetValid` is high for exactly one cycle per miss. That cycle is the one in which the beat for the missed word is accepted, and `cpuRetData` equals that beat's data.
- R6: In critical-word-first mode the missed word is the first beat. With no request stall and no wait cycles, `cpuRetValid` rises 2 cycles after the cycle in which the miss is accepted.
- R7: In early-restart mode the missed word is beat number (missed index). With no stalls or waits, `cpuRetValid` rises 2 + missed index cycles after acceptance.
- R8: `lineDone` is a one-cycle pulse in the cycle after the 16th beat. `missReady` is 0 from the cycle after acceptance through that pulse, and returns to 1 in the following cycle.
- R9: Miss inputs presented while a refill is in progress are ignored. No second request is issued and the refill in progress keeps its block address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| missValid | input | 1 | Miss request present |
| missReady | output | 1 | Controller idle; a miss is accepted when both are high |
| missBlkAddr | input | BLK_ADDR_W | Block address of the miss |
| missWordIdx | input | log2(WORDS) | Index of the missed word within the line |
| critFirstMode | input | 1 | 1 = critical-word-first wrap order, 0 = early restart in ascending order |
| memReqValid | output | 1 | Burst request to memory |
| memReqReady | input | 1 | Memory accepts the request |
| memReqBlkAddr | output | BLK_ADDR_W | Block address of the burst |
| memReqStartIdx | output | log2(WORDS) | First word index of the wrapping burst |
| memRspValid | input | 1 | A response beat is present |
| memRspData | input | WORD_W | Response beat data |
| cpuRetValid | output | 1 | Missed word returned to the processor |
| cpuRetData | output | WORD_W | Missed word data |
| fillWrEn | output | 1 | Line buffer write strobe |
| fillWrIdx | output | log2(WORDS) | Line buffer word position |
| fillWrData | output | WORD_W | Line buffer write data |
| lineDone | output | 1 | Whole line written |

## Verification
The bench runs the same missed index, 11, in both modes without waits. The start index and the return latency (2 against 13 cycles) show whether the mode actually changes the fetch order.

Index 15 is run in both modes to probe the wrap boundary:

- In critical-word-first mode it is combined with a stalled request and a wait before every odd beat. This separates correct beat counting from counting idle cycles.
- In early-restart mode it places the missed word on the final beat.

Index 0 is run in early-restart mode with irregular gaps, where both orders must give the same result.

A final run holds a second miss on the inputs during the whole burst. This shows whether the refill in progress is protected from new misses.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_BURST = 2'd2,
    ST_DONE  = 2'd3
  } refillState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureMiss;  // load miss fields, clear beat count
    logic takeBeat;     // advance beat count
  } refillStrobe_t;

endpackage

// File: rtl/refill_datapath.sv
module refill_datapath
  import refill_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int WORDS      = 16,
  parameter int BLK_ADDR_W = 26,
  localparam int IDX_W     = $clog2(WORDS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  refillStrobe_t         strobe,
  input  logic [BLK_ADDR_W-1:0] missBlkAddr,
  input  logic [IDX_W-1:0]      missWordIdx,
  input  logic                  critFirstMode,
  input  logic [WORD_W-1:0]     memRspData,
  output logic [BLK_ADDR_W-1:0] blkAddrQ,
  output logic [IDX_W-1:0]      startIdxQ,
  output logic [IDX_W-1:0]      wrIdx,
  output logic [WORD_W-1:0]     wrData,
  output logic                  hitMissed,
  output logic                  lastBeat
);

  localparam bit IS_POW2 = (WORDS == (1 << IDX_W));
  localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(WORDS - 1);

  logic [IDX_W-1:0] missIdxQ;
  logic [IDX_W-1:0] beatQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkAddrQ  <= '0;
      missIdxQ  <= '0;
      startIdxQ <= '0;
      beatQ     <= '0;
    end else if (strobe.captureMiss) begin
      blkAddrQ  <= missBlkAddr;
      missIdxQ  <= missWordIdx;
      startIdxQ <= critFirstMode ? missWordIdx : '0;
      beatQ     <= '0;
    end else if (strobe.takeBeat) begin
      beatQ     <= beatQ + 1'b1;
    end
  end

  // Wrapped write position: start + beat, modulo WORDS
  generate
    if (IS_POW2) begin : g_wrapPow2
      assign wrIdx = startIdxQ + beatQ;
    end else begin : g_wrapGeneric
      logic [IDX_W:0] rawSum;
      assign rawSum = {1'b0, startIdxQ} + {1'b0, beatQ};
      assign wrIdx  = (rawSum >= (IDX_W+1)'(WORDS))
                      ? IDX_W'(rawSum - (IDX_W+1)'(WORDS))
                      : rawSum[IDX_W-1:0];
    end
  endgenerate

  assign wrData    = memRspData;
  assign hitMissed = (wrIdx == missIdxQ);
  assign lastBeat  = (beatQ == LAST_BEAT);

endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          missValid,
  input  logic          memReqReady,
  input  logic          memRspValid,
  input  logic          hitMissed,
  input  logic          lastBeat,
  output refillStrobe_t strobe,
  output logic          missReady,
  output logic          memReqValid,
  output logic          fillWrEn,
  output logic          cpuRetValid,
  output logic          lineDone
);

  refillState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (missValid)   stateD = ST_REQ;
      ST_REQ:   if (memReqReady) stateD = ST_BURST;
      ST_BURST: if (memRspValid && lastBeat) stateD = ST_DONE;
      ST_DONE:  stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  assign missReady          = (stateQ == ST_IDLE);
  assign memReqValid        = (stateQ == ST_REQ);
  assign lineDone           = (stateQ == ST_DONE);
  assign strobe.captureMiss = missReady && missValid;
  assign strobe.takeBeat    = (stateQ == ST_BURST) && memRspValid;
  assign fillWrEn           = strobe.takeBeat;
  assign cpuRetValid        = strobe.takeBeat && hitMissed;

endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl
  import refill_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int WORDS      = 16,
  parameter int BLK_ADDR_W = 26,
  localparam int IDX_W     = $clog2(WORDS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  missValid,
  output logic                  missReady,
  input  logic [BLK_ADDR_W-1:0] missBlkAddr,
  input  logic [IDX_W-1:0]      missWordIdx,
  input  logic                  critFirstMode,
  output logic                  memReqValid,
  input  logic                  memReqReady,
  output logic [BLK_ADDR_W-1:0] memReqBlkAddr,
  output logic [IDX_W-1:0]      memReqStartIdx,
  input  logic                  memRspValid,
  input  logic [WORD_W-1:0]     memRspData,
  output logic                  cpuRetValid,
  output logic [WORD_W-1:0]     cpuRetData,
  output logic                  fillWrEn,
  output logic [IDX_W-1:0]      fillWrIdx,
  output logic [WORD_W-1:0]     fillWrData,
  output logic                  lineDone
);

  refillStrobe_t strobe;
  logic          hitMissed;
  logic          lastBeat;
  logic [WORD_W-1:0] beatData;

  refill_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .missValid   (missValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .hitMissed   (hitMissed),
    .lastBeat    (lastBeat),
    .strobe      (strobe),
    .missReady   (missReady),
    .memReqValid (memReqValid),
    .fillWrEn    (fillWrEn),
    .cpuRetValid (cpuRetValid),
    .lineDone    (lineDone)
  );

  refill_datapath #(
    .WORD_W     (WORD_W),
    .WORDS      (WORDS),
    .BLK_ADDR_W (BLK_ADDR_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .missBlkAddr   (missBlkAddr),
    .missWordIdx   (missWordIdx),
    .critFirstMode (critFirstMode),
    .memRspData    (memRspData),
    .blkAddrQ      (memReqBlkAddr),
    .startIdxQ     (memReqStartIdx),
    .wrIdx         (fillWrIdx),
    .wrData        (beatData),
    .hitMissed     (hitMissed),
    .lastBeat      (lastBeat)
  );

  assign fillWrData = beatData;
  assign cpuRetData = beatData;

endmodule

// File: rtl/cwf_refill_checker.sv
module cwf_refill_checker #(
  parameter int WORD_W     = 32,
  parameter int WORDS      = 16,
  parameter int BLK_ADDR_W = 26,
  localparam int IDX_W     = $clog2(WORDS)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  missValid,
  input logic                  missReady,
  input logic                  critFirstMode,
  input logic                  memReqValid,
  input logic                  memReqReady,
  input logic [BLK_ADDR_W-1:0] memReqBlkAddr,
  input logic [IDX_W-1:0]      memReqStartIdx,
  input logic                  memRspValid,
  input logic                  cpuRetValid,
  input logic [WORD_W-1:0]     cpuRetData,
  input logic                  fillWrEn,
  input logic [WORD_W-1:0]     fillWrData,
  input logic                  lineDone
);

  logic modeQ;
  logic firstPendQ;
  logic retSeenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ      <= 1'b0;
      firstPendQ <= 1'b0;
      retSeenQ   <= 1'b0;
    end else begin
      if (missValid && missReady) begin
        modeQ    <= critFirstMode;
        retSeenQ <= 1'b0;
      end else if (cpuRetValid) begin
        retSeenQ <= 1'b1;
      end
      if (memReqValid && memReqReady) firstPendQ <= 1'b1;
      else if (fillWrEn)              firstPendQ <= 1'b0;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) $rose(rstN) |->
      missReady && !memReqValid && !fillWrEn && !lineDone);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      memReqValid && !memReqReady |=>
        memReqValid && $stable(memReqBlkAddr) && $stable(memReqStartIdx));

  p_no_gap_write_r4: assert property (@(posedge clk) disable iff (!rstN)
      !memRspValid |-> !fillWrEn);

  p_ret_is_beat_r5: assert property (@(posedge clk) disable iff (!rstN)
      cpuRetValid |-> fillWrEn && (cpuRetData == fillWrData));

  p_single_ret_r5: assert property (@(posedge clk) disable iff (!rstN)
      cpuRetValid |-> !retSeenQ);

  p_cwf_first_beat_r6: assert property (@(posedge clk) disable iff (!rstN)
      firstPendQ && fillWrEn && modeQ |-> cpuRetValid);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
      lineDone |=> !lineDone && missReady);

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
      (memReqValid || fillWrEn || lineDone) |-> !missReady);

endmodule

bind cwf_refill_ctrl cwf_refill_checker #(
  .WORD_W     (WORD_W),
  .WORDS      (WORDS),
  .BLK_ADDR_W (BLK_ADDR_W)
) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .missValid      (missValid),
  .missReady      (missReady),
  .critFirstMode  (critFirstMode),
  .memReqValid    (memReqValid),
  .memReqReady    (memReqReady),
  .memReqBlkAddr  (memReqBlkAddr),
  .memReqStartIdx (memReqStartIdx),
  .memRspValid    (memRspValid),
  .cpuRetValid    (cpuRetValid),
  .cpuRetData     (cpuRetData),
  .fillWrEn       (fillWrEn),
  .fillWrData     (fillWrData),
  .lineDone       (lineDone)
);

// File: tb/test_cwf_refill_ctrl.sv
`timescale 1ns/100ps
module test_cwf_refill_ctrl;

  localparam int WORD_W = 32;
  localparam int WORDS  = 16;
  localparam int BLK_W  = 26;
  localparam int IDX_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missValid = 1'b0;
  logic missReady;
  logic [BLK_W-1:0] missBlkAddr = '0;
  logic [IDX_W-1:0] missWordIdx = '0;
  logic critFirstMode = 1'b0;
  logic memReqValid;
  logic memReqReady = 1'b0;
  logic [BLK_W-1:0] memReqBlkAddr;
  logic [IDX_W-1:0] memReqStartIdx;
  logic memRspValid = 1'b0;
  logic [WORD_W-1:0] memRspData = '0;
  logic cpuRetValid;
  logic [WORD_W-1:0] cpuRetData;
  logic fillWrEn;
  logic [IDX_W-1:0] fillWrIdx;
  logic [WORD_W-1:0] fillWrData;
  logic lineDone;

  always #2.5 clk = ~clk;

  cwf_refill_ctrl #(.WORD_W(WORD_W), .WORDS(WORDS), .BLK_ADDR_W(BLK_W)) i_cwf_refill_ctrl (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missReady(missReady),
    .missBlkAddr(missBlkAddr), .missWordIdx(missWordIdx), .critFirstMode(critFirstMode),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqBlkAddr(memReqBlkAddr),
    .memReqStartIdx(memReqStartIdx), .memRspValid(memRspValid), .memRspData(memRspData),
    .cpuRetValid(cpuRetValid), .cpuRetData(cpuRetData), .fillWrEn(fillWrEn),
    .fillWrIdx(fillWrIdx), .fillWrData(fillWrData), .lineDone(lineDone));

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [WORD_W-1:0] wordOf(input logic [BLK_W-1:0] blk, input int idx);
    return (32'(blk) * 32'd16 + 32'(idx)) ^ 32'hA5C3_0000;
  endfunction

  function automatic int gapsBefore(input int pat, input int beat);
    if (pat == 1) return beat % 2;
    if (pat == 2) return beat % 3;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor, sampled 1 ns after the falling edge
  logic [BLK_W-1:0] curBlk = '0;
  logic [WORDS-1:0] seen;
  int wrCount, dupCount, dataErr, gapWrites, retCount, retCyc, doneCount, doneCyc, reqCount;
  logic [WORD_W-1:0] retData;

  task automatic clearMon();
    seen = '0; wrCount = 0; dupCount = 0; dataErr = 0; gapWrites = 0;
    retCount = 0; retCyc = -1; doneCount = 0; doneCyc = -1; reqCount = 0; retData = '0;
  endtask

  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (fillWrEn) begin
        wrCount++;
        if (seen[fillWrIdx]) dupCount++;
        seen[fillWrIdx] = 1'b1;
        if (fillWrData != wordOf(curBlk, int'(fillWrIdx))) dataErr++;
        if (!memRspValid) gapWrites++;
      end
      if (cpuRetValid) begin
        retCount++; retCyc = cyc; retData = cpuRetData;
      end
      if (lineDone) begin
        doneCount++; doneCyc = cyc;
      end
      if (memReqValid && memReqReady) reqCount++;
    end
  end

  task automatic runMiss(input logic [BLK_W-1:0] blk, input int idx, input bit mode,
                         input int pat, input int stall, input bit holdOther);
    int t0, startExp, pos, expLat, expCyc, lastCyc, gapSum, lat;
    @(negedge clk);
    clearMon();
    curBlk = blk;
    missValid = 1'b1; missBlkAddr = blk; missWordIdx = IDX_W'(idx); critFirstMode = mode;
    memReqReady = (stall == 0);
    t0 = cyc;
    @(negedge clk);
    missValid = holdOther;
    if (holdOther) begin
      missBlkAddr = blk ^ 26'h155; missWordIdx = IDX_W'(idx + 3); critFirstMode = ~mode;
    end
    startExp = mode ? idx : 0;
    #1;
    check(memReqValid == 1'b1, "R2 request raised", memReqValid, 1);
    check(memReqBlkAddr == blk, "R2 request block address", memReqBlkAddr, blk);
    check(int'(memReqStartIdx) == startExp, "R2 start index", memReqStartIdx, startExp);
    for (int s = 0; s < stall; s++) @(negedge clk);
    if (stall > 0) begin
      memReqReady = 1'b1;
      #1;
      check(memReqValid && memReqBlkAddr == blk && int'(memReqStartIdx) == startExp,
            "R2 request held while stalled", memReqStartIdx, startExp);
    end
    @(negedge clk);
    memReqReady = 1'b0;
    pos = (idx - startExp + WORDS) % WORDS;
    gapSum = 0;
    for (int b = 0; b <= pos; b++) gapSum += gapsBefore(pat, b);
    expLat = 2 + stall + pos + gapSum;
    expCyc = -1; lastCyc = -1;
    for (int b = 0; b < WORDS; b++) begin
      for (int g = 0; g < gapsBefore(pat, b); g++) begin
        memRspValid = 1'b0;
        memRspData = 32'hDEAD_0000 + 32'(g);
        @(negedge clk);
      end
      memRspValid = 1'b1;
      memRspData = wordOf(blk, (startExp + b) % WORDS);
      if (b == pos) expCyc = cyc;
      if (b == WORDS - 1) lastCyc = cyc;
      if (b == WORDS - 2) missValid = 1'b0;
      @(negedge clk);
    end
    memRspValid = 1'b0;
    memRspData = '0;
    #1;
    check(missReady == 1'b0, "R8 not ready during done pulse", missReady, 0);
    @(negedge clk);
    #1;
    check(missReady == 1'b1, "R8 ready after done pulse", missReady, 1);
    repeat (2) @(negedge clk);
    #1;
    check(wrCount == WORDS && seen == '1 && dupCount == 0, "R3 every position written once",
          wrCount, WORDS);
    check(dataErr == 0, "R3 position/data mapping", dataErr, 0);
    check(gapWrites == 0, "R4 no write in wait cycles", gapWrites, 0);
    check(retCount == 1, "R5 single processor return", retCount, 1);
    check(retCyc == expCyc, "R5 return in missed beat cycle", retCyc, expCyc);
    check(retData == wordOf(blk, idx), "R5 returned data", retData, wordOf(blk, idx));
    lat = retCyc - t0;
    if (mode) check(lat == expLat, "R6 critical-word-first latency", lat, expLat);
    else      check(lat == expLat, "R7 early-restart latency", lat, expLat);
    check(doneCount == 1 && doneCyc == lastCyc + 1, "R8 line done pulse", doneCyc, lastCyc + 1);
    check(reqCount == 1, "R9 one request per miss", reqCount, 1);
    $display("miss blk=%0h idx=%0d mode=%0d latency=%0d", blk, idx, mode, lat);
  endtask

  task automatic testReset();
    #1;
    check(missReady == 1'b1, "R1 missReady after reset", missReady, 1);
    check(!memReqValid && !fillWrEn && !cpuRetValid && !lineDone, "R1 outputs idle after reset",
          {memReqValid, fillWrEn, cpuRetValid, lineDone}, 0);
  endtask

  task automatic testCwfMid();   runMiss(26'h0012345, 11, 1'b1, 0, 0, 1'b0); endtask // R6
  task automatic testErMid();    runMiss(26'h0012345, 11, 1'b0, 0, 0, 1'b0); endtask // R7
  task automatic testCwfWrap();  runMiss(26'h3ABCDE0, 15, 1'b1, 1, 3, 1'b0); endtask // R3 R4
  task automatic testErLast();   runMiss(26'h0000777, 15, 1'b0, 0, 1, 1'b0); endtask // R7
  task automatic testErZero();   runMiss(26'h1F00F00, 0,  1'b0, 2, 0, 1'b0); endtask // R4
  task automatic testBusyHold(); runMiss(26'h2468ACE, 6,  1'b1, 2, 2, 1'b1); endtask // R9

  initial begin
    clearMon();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCwfMid();
    testErMid();
    testCwfWrap();
    testErLast();
    testErZero();
    testBusyHold();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule